// File: doc/BRIEF.md
# Optical Black Clamp Datapath

This block sits after the analog-to-digital converter of an imaging front end. It takes one digitised pixel per clock and adds a signed digital offset to each one. While a window strobe marks optical black pixels, it compares each corrected black pixel against a programmable target code. It then nudges the offset by a fraction of that difference, so the black level of the image settles on the target.

A second strobe marks horizontal blanking and forces the emitted data to zero. The black-window strobe takes priority whenever the two strobes overlap. Control inputs select a fast loop with half the time constant, freeze the loop, choose between a fixed target and a programmable one, and release the output pads to high impedance through an output-enable pin. Every sample takes a fixed nine-register path from input to output.

Top module: `black_clamp_pipe`

## Requirements
- R1: Every sample takes exactly nine registers from input to output. A sample captured on clock edge n drives `pix_out` from edge n+8 onward, and samples leave in the order they arrived.
- R2: The corrected value is the input code plus the signed offset, limited to the range 0 to 16383.
- R3: A sample captured with `blank_win` high and `ob_win` low leaves the block as 0.
- R4: A sample captured with both `ob_win` and `blank_win` high leaves as its corrected value, not as 0, and it still updates the loop.
- R5: The target is 492 when `lvl_sel` is 0 and 4 × `lvl_code` when `lvl_sel` is 1. After a long run of constant black pixels, the corrected black output lies in [target − (2^K − 1), target].
- R6: For each sample captured with `ob_win` high and `clamp_off` low, the offset becomes offset + ((target − corrected) arithmetically shifted right by K). K is 8 when `fast_loop` is 0 and 7 when it is 1. With `ob_win` low, the offset holds.
- R7: While `clamp_off` is 1, black-window samples leave the offset unchanged, and later pixels are corrected by the held offset.
- R8: Reset clears the offset to 0, the pipeline contents to 0 and `pix_oe` to 1. The first samples after reset therefore pass through unchanged.
- R9: `pix_oe` equals the inverse of `out_off` as captured on the previous clock edge. Data keeps flowing while the pads are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_in | input | 14 | Digitised input sample |
| ob_win | input | 1 | High on optical black pixels (clamp window) |
| blank_win | input | 1 | High on pixels to be blanked |
| clamp_off | input | 1 | 1 freezes the offset |
| fast_loop | input | 1 | 1 selects the halved loop time constant |
| lvl_sel | input | 1 | 1 takes the target from lvl_code, 0 uses 492 |
| lvl_code | input | 8 | Programmable target, in units of 4 codes |
| out_off | input | 1 | 1 requests high-impedance output pads |
| pix_out | output | 14 | Corrected, delayed pixel |
| pix_oe | output | 1 | Output-pad enable, 1 drives the pads |

## Verification
A wrong offset is visible at `pix_out` eight clocks after the first black pixel that it affects. From then on it shifts every later pixel by the same error until the loop pulls it back. A fault in the update step, such as a wrong shift or a wrong target, appears as a drift that grows across a black window, so a per-pixel comparison with an exact model catches it within one window. A pipeline-length fault or a wrong blanking priority shows within the first nine output pixels of the affected pattern.

// File: rtl/black_clamp_pkg.sv
package black_clamp_pkg;

   // Saturate a signed sum into an unsigned pixel code of width w.
   function automatic logic [31:0] clip_code(input logic signed [31:0] v, input int w);
      logic signed [31:0] top;
      top = (32'sd1 <<< w) - 32'sd1;
      if (v < 0)
         return 32'd0;
      else if (v > top)
         return top;
      else
         return v;
   endfunction

   // Pixel-side strobes carried alongside a captured sample.
   typedef struct packed {
      logic ob;
      logic blank;
   } strobe_t;

endpackage

// File: rtl/black_clamp_target.sv
module black_clamp_target #(
   parameter int LVL_W     = 8,
   parameter int TGT_W     = 12,
   parameter int FIX_LEVEL = 492,
   parameter int SCALE_SH  = 2
) (
   input  logic             lvl_sel,
   input  logic [LVL_W-1:0] lvl_code,
   output logic [TGT_W-1:0] tgt
);
   localparam int SCALED_W = LVL_W + SCALE_SH;

   if (SCALED_W > TGT_W) begin : g_bad_w
      $error("black_clamp_target: TGT_W too narrow for scaled level");
   end
   if (FIX_LEVEL >= (1 << TGT_W)) begin : g_bad_fix
      $error("black_clamp_target: FIX_LEVEL does not fit TGT_W");
   end

   logic [SCALED_W-1:0] scaled;

   if (SCALE_SH == 0) begin : g_noscale
      assign scaled = lvl_code;
   end else begin : g_scale
      assign scaled = {lvl_code, {SCALE_SH{1'b0}}};
   end

   always_comb begin
      if (lvl_sel)
         tgt = TGT_W'(scaled);
      else
         tgt = TGT_W'(FIX_LEVEL);
   end
endmodule

// File: rtl/black_clamp_loop.sv
module black_clamp_loop
   import black_clamp_pkg::*;
#(
   parameter int PIX_W  = 14,
   parameter int OFS_W  = 16,
   parameter int TGT_W  = 12,
   parameter int K_NORM = 8,
   parameter int K_FAST = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PIX_W-1:0]        s1_pix,
   input  strobe_t                 s1_str,
   input  logic                    clamp_off,
   input  logic                    fast_loop,
   input  logic [TGT_W-1:0]        tgt,
   output logic [PIX_W-1:0]        corr_q,
   output logic signed [OFS_W-1:0] ofs_q
);
   localparam int SW      = OFS_W + 2;
   localparam int PIX_MAX = (1 << PIX_W) - 1;

   if (OFS_W < PIX_W + 2) begin : g_bad_ofs
      $error("black_clamp_loop: OFS_W must be at least PIX_W+2");
   end
   if (TGT_W > PIX_W) begin : g_bad_tgt
      $error("black_clamp_loop: target wider than pixel");
   end
   if (K_NORM < 1 || K_FAST < 1 || K_NORM >= SW || K_FAST >= SW) begin : g_bad_k
      $error("black_clamp_loop: shift out of range");
   end

   logic signed [SW-1:0] sum;
   logic [PIX_W-1:0]     corr;
   logic signed [SW-1:0] err;
   logic signed [SW-1:0] step;
   logic signed [SW-1:0] ofs_next;
   logic                 upd;

   // correction with saturation
   always_comb begin
      sum = SW'(ofs_q) + $signed({{(SW-PIX_W){1'b0}}, s1_pix});
      if (sum < 0)
         corr = '0;
      else if (sum > SW'(PIX_MAX))
         corr = PIX_W'(PIX_MAX);
      else
         corr = sum[PIX_W-1:0];
   end

   assign err = $signed({{(SW-TGT_W){1'b0}}, tgt}) - $signed({{(SW-PIX_W){1'b0}}, corr});

   // shift variant chosen by parameters
   if (K_NORM == K_FAST) begin : g_one_k
      assign step = err >>> K_NORM;
   end else begin : g_two_k
      always_comb begin
         if (fast_loop)
            step = err >>> K_FAST;
         else
            step = err >>> K_NORM;
      end
   end

   assign ofs_next = SW'(ofs_q) + step;
   assign upd      = s1_str.ob && !clamp_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= '0;
      end else if (upd) begin
         ofs_q <= ofs_next[OFS_W-1:0];
      end
   end

   // blanking only when the black window is not active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         corr_q <= '0;
      end else if (s1_str.blank && !s1_str.ob) begin
         corr_q <= '0;
      end else begin
         corr_q <= corr;
      end
   end
endmodule

// File: rtl/black_clamp_delay.sv
module black_clamp_delay #(
   parameter int W     = 14,
   parameter int DEPTH = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (DEPTH < 0) begin : g_bad_depth
      $error("black_clamp_delay: negative depth");
   end

   if (DEPTH == 0) begin : g_wire
      assign dout = din;
   end else begin : g_regs
      logic [W-1:0] tap [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  tap[i] <= '0;
               else
                  tap[i] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  tap[i] <= '0;
               else
                  tap[i] <= tap[i-1];
            end
         end
      end
      assign dout = tap[DEPTH-1];
   end
endmodule

// File: rtl/black_clamp_pipe.sv
module black_clamp_pipe
   import black_clamp_pkg::*;
#(
   parameter int PIX_W     = 14,
   parameter int OFS_W     = 16,
   parameter int LVL_W     = 8,
   parameter int LAT       = 9,
   parameter int K_NORM    = 8,
   parameter int K_FAST    = 7,
   parameter int FIX_LEVEL = 492,
   parameter int SCALE_SH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix_in,
   input  logic             ob_win,
   input  logic             blank_win,
   input  logic             clamp_off,
   input  logic             fast_loop,
   input  logic             lvl_sel,
   input  logic [LVL_W-1:0] lvl_code,
   input  logic             out_off,
   output logic [PIX_W-1:0] pix_out,
   output logic             pix_oe
);
   localparam int TGT_W  = LVL_W + SCALE_SH;
   localparam int TAIL_N = LAT - 2;

   if (LAT < 2) begin : g_bad_lat
      $error("black_clamp_pipe: LAT must cover capture and correction stages");
   end

   logic [PIX_W-1:0]        s1_pix;
   strobe_t                 s1_str;
   logic                    s1_ob;
   logic                    s1_blank;
   logic [TGT_W-1:0]        tgt;
   logic [PIX_W-1:0]        corr_q;
   logic signed [OFS_W-1:0] ofs_q;

   // capture stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_pix <= '0;
         s1_str <= '0;
      end else begin
         s1_pix       <= pix_in;
         s1_str.ob    <= ob_win;
         s1_str.blank <= blank_win;
      end
   end

   assign s1_ob    = s1_str.ob;
   assign s1_blank = s1_str.blank;

   black_clamp_target #(
      .LVL_W    (LVL_W),
      .TGT_W    (TGT_W),
      .FIX_LEVEL(FIX_LEVEL),
      .SCALE_SH (SCALE_SH)
   ) u_tgt (
      .lvl_sel (lvl_sel),
      .lvl_code(lvl_code),
      .tgt     (tgt)
   );

   black_clamp_loop #(
      .PIX_W (PIX_W),
      .OFS_W (OFS_W),
      .TGT_W (TGT_W),
      .K_NORM(K_NORM),
      .K_FAST(K_FAST)
   ) u_loop (
      .clk      (clk),
      .rst_n    (rst_n),
      .s1_pix   (s1_pix),
      .s1_str   (s1_str),
      .clamp_off(clamp_off),
      .fast_loop(fast_loop),
      .tgt      (tgt),
      .corr_q   (corr_q),
      .ofs_q    (ofs_q)
   );

   black_clamp_delay #(
      .W    (PIX_W),
      .DEPTH(TAIL_N)
   ) u_tail (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (corr_q),
      .dout (pix_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pix_oe <= 1'b1;
      else
         pix_oe <= !out_off;
   end
endmodule

// File: rtl/black_clamp_chk.sv
module black_clamp_chk #(
   parameter int PIX_W = 14,
   parameter int OFS_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    out_off,
   input logic                    pix_oe,
   input logic                    clamp_off,
   input logic                    s1_ob,
   input logic                    s1_blank,
   input logic [PIX_W-1:0]        corr_q,
   input logic signed [OFS_W-1:0] ofs_q
);
   logic warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         warm <= 1'b0;
      else
         warm <= 1'b1;
   end

   // R9
   oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (pix_oe == !$past(out_off)));

   // R3
   blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_blank && !s1_ob) |=> (corr_q == '0));

   // R7
   frozen_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_ob && clamp_off) |=> $stable(ofs_q));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_ob |=> $stable(ofs_q));
endmodule

bind black_clamp_pipe black_clamp_chk #(
   .PIX_W(PIX_W),
   .OFS_W(OFS_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .out_off  (out_off),
   .pix_oe   (pix_oe),
   .clamp_off(clamp_off),
   .s1_ob    (s1_ob),
   .s1_blank (s1_blank),
   .corr_q   (corr_q),
   .ofs_q    (ofs_q)
);

// File: tb/black_clamp_pipe_test.sv
`timescale 1ns/1ps
module black_clamp_pipe_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] pix_in = '0;
   logic        ob_win = 1'b0;
   logic        blank_win = 1'b0;
   logic        clamp_off = 1'b0;
   logic        fast_loop = 1'b0;
   logic        lvl_sel = 1'b0;
   logic [7:0]  lvl_code = '0;
   logic        out_off = 1'b0;
   logic [13:0] pix_out;
   logic        pix_oe;

   always #2.5 clk = ~clk;

   black_clamp_pipe uut (
      .clk(clk), .rst_n(rst_n), .pix_in(pix_in), .ob_win(ob_win),
      .blank_win(blank_win), .clamp_off(clamp_off), .fast_loop(fast_loop),
      .lvl_sel(lvl_sel), .lvl_code(lvl_code), .out_off(out_off),
      .pix_out(pix_out), .pix_oe(pix_oe)
   );

   int    total = 0;
   int    bad = 0;
   int    cnt = 0;
   int    m_ofs = 0;
   bit    done = 0;
   int    exp_mem [0:16383];
   bit    oe_mem  [0:16383];
   string tag_mem [0:16383];
   string force_tag = "";

   function automatic int sat_pix(input int v);
      if (v < 0) return 0;
      if (v > 16383) return 16383;
      return v;
   endfunction

   function automatic int target_now();
      return lvl_sel ? 4 * int'(lvl_code) : 492;
   endfunction

   function automatic int kshift();
      return fast_loop ? 7 : 8;
   endfunction

   task automatic report(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, cnt, act, expv);
      end
   endtask

   task automatic check_out();
      if (cnt >= 9)
         report(tag_mem[cnt-8], int'(pix_out), exp_mem[cnt-8]);
      else
         report("R8", int'(pix_out), 0);
      if (cnt >= 1)
         report("R9", int'(pix_oe), int'(oe_mem[cnt]));
      else
         report("R8", int'(pix_oe), 1);
   endtask

   task automatic step(input int x, input bit ob, input bit bl);
      int c;
      int v;
      check_out();
      pix_in = 14'(x);
      ob_win = ob;
      blank_win = bl;
      c = sat_pix(x + m_ofs);
      v = (bl && !ob) ? 0 : c;
      exp_mem[cnt+1] = v;
      oe_mem[cnt+1] = !out_off;
      if (force_tag != "")             tag_mem[cnt+1] = force_tag;
      else if (ob && clamp_off)        tag_mem[cnt+1] = "R7";
      else if (bl && !ob)              tag_mem[cnt+1] = "R3";
      else if (ob && bl)               tag_mem[cnt+1] = "R4";
      else if (ob)                     tag_mem[cnt+1] = "R6";
      else if (c == 0 || c == 16383)   tag_mem[cnt+1] = "R2";
      else                             tag_mem[cnt+1] = "R1";
      if (ob && !clamp_off)
         m_ofs = m_ofs + ((target_now() - c) >>> kshift());
      @(posedge clk);
      cnt++;
      @(negedge clk);
   endtask

   // one black-free sample, then new controls take effect for later samples
   task automatic set_ctrl(input bit off, input bit fast, input bit sel, input int code);
      step(1000, 0, 0);
      clamp_off = off;
      fast_loop = fast;
      lvl_sel = sel;
      lvl_code = 8'(code);
   endtask

   // R5: settle on constant black pixels, then bound the output
   task automatic settle(input bit sel, input int code);
      int t;
      int lo;
      set_ctrl(0, 1, sel, code);
      for (int i = 0; i < 1600; i++) step(300, 1, 0);
      t = target_now();
      lo = t - 127;
      total++;
      if (!(int'(pix_out) <= t && int'(pix_out) >= lo && int'(pix_out) >= 0)) begin
         bad++;
         $display("FAIL R5 actual=%0d expected=[%0d..%0d]", pix_out, lo, t);
      end
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_0042);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: first samples pass untouched, reset state checked by check_out
      for (int i = 0; i < 12; i++) step(100 * i + 7, 0, 0);
      // R1: single marker between zeros
      force_tag = "R1";
      step(9999, 0, 0);
      for (int i = 0; i < 10; i++) step(0, 0, 0);
      force_tag = "";
      // R3 / R4 directed overlap
      for (int i = 0; i < 5; i++) step(4000, 0, 1);
      for (int i = 0; i < 5; i++) step(4000, 1, 1);
      // R6 normal vs fast step from a black run
      set_ctrl(0, 0, 0, 0);
      for (int i = 0; i < 40; i++) step(100, 1, 0);
      set_ctrl(0, 1, 0, 0);
      for (int i = 0; i < 40; i++) step(100, 1, 0);
      // R7 frozen loop, then bright pixels with held offset
      set_ctrl(1, 0, 1, 10);
      for (int i = 0; i < 30; i++) step(2500, 1, 0);
      for (int i = 0; i < 10; i++) step(5000, 0, 0);
      // R5 targets
      settle(0, 0);
      settle(1, 200);
      settle(1, 255);
      settle(1, 0);
      // R2 saturation: negative offset with low input, then top code
      for (int i = 0; i < 10; i++) step(0, 0, 0);
      for (int i = 0; i < 10; i++) step(16383, 0, 0);
      // random lines
      for (int n = 0; n < 3000; n++) begin
         int p;
         bit ob;
         bit bl;
         int x;
         if (n % 200 == 0)
            set_ctrl(($urandom % 6) == 0, $urandom % 2, $urandom % 2, $urandom % 256);
         if (($urandom % 20) == 0) out_off = ~out_off;
         p = n % 100;
         ob = (p < 20);
         bl = (p >= 15 && p < 30);
         if (ob) x = 150 + ($urandom % 600);
         else if (($urandom % 10) == 0) x = (($urandom % 2) == 0) ? 0 : 16383;
         else x = $urandom % 16384;
         step(x, ob, bl);
      end
      out_off = 1'b0;
      for (int i = 0; i < 10; i++) step(0, 0, 0);
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule